// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a two-wire serial slave (SMBus/I2C compatible) that sits on the system clock. It gives a bus master access to four internal registers. SCL and SDA are brought into the clock domain through a synchronizer, and start and stop conditions are found by edge detection. The block answers to a 7-bit address made of a fixed upper nibble and three strap pins, and it pulls SDA low through an open-drain output enable.

A write transaction first carries a pointer byte and then optional data bytes. A read transaction returns the register that the stored pointer selects. The pointer survives from one transaction to the next, so repeated reads of the same register need no new pointer write. A pointer byte with any of its reserved upper bits set is refused, and the rest of that transaction is dropped.

The temperature value comes from outside on `temp_i` and is read-only. The configuration register and the two threshold registers are held inside the block and driven out on their own ports.

Top module: `tw_ptr_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, `cfg_o` is 8'h00, `hyst_o` is 16'h4B00, `olim_o` is 16'h5000 and the pointer selects the temperature register (code 00).
- R2: The first byte after a start is address[6:0] followed by the read/write bit (1 = read), sent MSB first. The slave drives ACK (SDA low) on the ninth clock only if the address equals {4'b1001, strap_i}. On a mismatch it leaves SDA released for every later byte until the next start, and no register changes.
- R3: After an address with R/W = 0, the next byte is a pointer. It is ACKed when bits [7:2] are zero, and bits [1:0] then become the stored pointer: 00 temperature, 01 configuration, 10 hysteresis threshold, 11 over-limit threshold.
- R4: A pointer byte with any of bits [7:2] nonzero is NACKed and the stored pointer stays unchanged. Later bytes in the same transaction get no ACK and change no register.
- R5: The pointer is retained across stop conditions. A transaction that begins with R/W = 1 returns the register that was last selected.
- R6: Every data byte written after an accepted pointer is ACKed. The configuration register takes each written byte. A 16-bit threshold register takes its first written byte as the high half and its second as the low half, and it updates only once the second byte has arrived.
- R7: Data bytes written while the pointer is 00 are ACKed, but no register changes.
- R8: A read sends bytes MSB first. A 16-bit register sends its high byte first, then its low byte, and keeps alternating while the master ACKs. The configuration register repeats its single byte. After a master NACK the slave releases SDA and sends nothing more.
- R9: A start seen in the middle of a byte throws that byte away and restarts address reception. A pointer that was already accepted in that transaction stays stored.
- R10: `sda_oe_o` changes only after a detected SCL falling edge, a start or a stop. After a stop, `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three address bits from board straps |
| temp_i | input | 16 | Temperature value, returned when the pointer is 00 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_o | output | 8 | Configuration register contents |
| hyst_o | output | 16 | Hysteresis threshold register contents |
| olim_o | output | 16 | Over-limit threshold register contents |

## Verification
The bench builds the block with its default parameters: a fixed nibble of 1001, a two-flop synchronizer, and the reset values 16'h4B00 and 16'h5000 for the thresholds. The straps are tied to 3'b101, which makes 7'h4D the device address and 7'h4B a near miss for the mismatch test. SCL phases last ten system clocks, so the synchronizer and the registered output settle well inside each phase. This allows the bench to sample every ACK and data bit at mid-high, the way a real master does.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 2;
  localparam int CNT_W  = 4;

  localparam logic [PTR_W-1:0] SEL_TEMP = 2'd0;
  localparam logic [PTR_W-1:0] SEL_CFG  = 2'd1;
  localparam logic [PTR_W-1:0] SEL_HYST = 2'd2;
  localparam logic [PTR_W-1:0] SEL_OLIM = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 2,
  parameter int N = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage [N];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) stage[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stage[0] <= d_i;
      for (int i = 1; i < N; i++) stage[i] <= stage[i-1];
      prev <= stage[N-1];
    end
  end

  assign q_o    = stage[N-1];
  assign rise_o = stage[N-1] & ~prev;
  assign fall_o = ~stage[N-1] & prev;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST  = 8'h00,
  parameter logic [WORD_W-1:0] HYST_RST = 16'h4B00,
  parameter logic [WORD_W-1:0] OLIM_RST = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] temp_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [WORD_W-1:0] hyst_o,
  output logic [WORD_W-1:0] olim_o
);
  localparam int N_THR = 2;
  logic [WORD_W-1:0] thr [N_THR];

  always_ff @(posedge clk) begin
    if (rst) cfg_o <= CFG_RST;
    else if (we_i && sel_i == SEL_CFG) cfg_o <= wdata_i[WORD_W-1 -: BYTE_W];
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) thr[g] <= (g == 0) ? HYST_RST : OLIM_RST;
      else if (we_i && sel_i == PTR_W'(g + 2)) thr[g] <= wdata_i;
    end
  end

  assign hyst_o = thr[0];
  assign olim_o = thr[1];

  always_comb begin
    case (sel_i)
      SEL_TEMP: rdata_o = temp_i;
      SEL_CFG:  rdata_o = {cfg_o, {(WORD_W-BYTE_W){1'b0}}};
      SEL_HYST: rdata_o = thr[0];
      default:  rdata_o = thr[1];
    endcase
  end

  // R7: a write strobe aimed at the temperature slot leaves every register as it was
  assert_temp_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel_i == SEL_TEMP) |=> ($stable(cfg_o) && $stable(hyst_o) && $stable(olim_o)));
endmodule

// File: rtl/tw_ptr_slave.sv
module tw_ptr_slave
  import tw_pkg::*;
#(
  parameter logic [3:0]        ADDR_FIXED = 4'b1001,
  parameter int                SYNC_N     = 2,
  parameter logic [BYTE_W-1:0] CFG_RST    = 8'h00,
  parameter logic [WORD_W-1:0] HYST_RST   = 16'h4B00,
  parameter logic [WORD_W-1:0] OLIM_RST   = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [WORD_W-1:0] temp_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [WORD_W-1:0] hyst_o,
  output logic [WORD_W-1:0] olim_o
);
  logic [1:0] lines, rise, fall;
  tw_sync #(.W(2), .N(SYNC_N), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d_i({scl_i, sda_i}),
    .q_o(lines), .rise_o(rise), .fall_o(fall));

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  assign scl_s    = lines[1];
  assign sda_s    = lines[0];
  assign scl_rise = rise[1];
  assign scl_fall = fall[1];
  assign start    = fall[0] & scl_s & ~scl_rise;
  assign stop     = rise[0] & scl_s & ~scl_rise;

  tw_state_e         state;
  logic [CNT_W-1:0]  bitc;
  logic [BYTE_W-1:0] shreg, tx, whi;
  logic [WORD_W-1:0] hold, rf_rdata, wdata;
  logic [PTR_W-1:0]  ptr;
  logic              rw, bidx, mack, we;

  logic byte_done, addr_hit, ptr_ok;
  logic [BYTE_W-1:0] next_rd;
  assign byte_done = scl_fall && (bitc == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg[7:1] == {ADDR_FIXED, strap_i});
  assign ptr_ok    = (shreg[7:2] == '0);
  assign next_rd   = (ptr == SEL_CFG) ? hold[WORD_W-1 -: BYTE_W]
                   : (bidx ? hold[BYTE_W-1:0] : hold[WORD_W-1 -: BYTE_W]);
  assign we        = (state == ST_WDAT) && byte_done && (ptr == SEL_CFG || bidx);
  assign wdata     = (ptr == SEL_CFG) ? {shreg, {BYTE_W{1'b0}}} : {whi, shreg};

  tw_regfile #(.CFG_RST(CFG_RST), .HYST_RST(HYST_RST), .OLIM_RST(OLIM_RST)) u_rf (
    .clk(clk), .rst(rst), .we_i(we), .sel_i(ptr), .wdata_i(wdata),
    .temp_i(temp_i), .rdata_o(rf_rdata), .cfg_o(cfg_o), .hyst_o(hyst_o),
    .olim_o(olim_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bitc <= '0; shreg <= '0; tx <= '0; whi <= '0;
      hold <= '0; ptr <= SEL_TEMP; rw <= 1'b0; bidx <= 1'b0; mack <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start) begin
      state <= ST_ADDR; bitc <= '0; sda_oe_o <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE; sda_oe_o <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            bitc  <= bitc + CNT_W'(1);
          end
          ST_RDAT: bitc <= bitc + CNT_W'(1);
          ST_RACK: mack <= ~sda_s;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state)
          ST_ADDR: if (byte_done) begin
            if (addr_hit) begin
              state <= ST_AACK; sda_oe_o <= 1'b1; rw <= shreg[0];
            end else state <= ST_IDLE;
          end
          ST_AACK: begin
            bitc <= '0;
            if (rw) begin
              hold <= rf_rdata; tx <= rf_rdata[WORD_W-1 -: BYTE_W];
              sda_oe_o <= ~rf_rdata[WORD_W-1]; bidx <= 1'b1; state <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0; state <= ST_PTR;
            end
          end
          ST_PTR: if (byte_done) begin
            if (ptr_ok) begin
              ptr <= shreg[PTR_W-1:0]; sda_oe_o <= 1'b1; state <= ST_PACK;
            end else state <= ST_IDLE;
          end
          ST_PACK: begin
            sda_oe_o <= 1'b0; bitc <= '0; bidx <= 1'b0; state <= ST_WDAT;
          end
          ST_WDAT: if (byte_done) begin
            if (!bidx) whi <= shreg;
            sda_oe_o <= 1'b1; state <= ST_WACK;
          end
          ST_WACK: begin
            sda_oe_o <= 1'b0; bitc <= '0; bidx <= ~bidx; state <= ST_WDAT;
          end
          ST_RDAT: begin
            if (byte_done) begin
              sda_oe_o <= 1'b0; state <= ST_RACK;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b0}; sda_oe_o <= ~tx[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (mack) begin
              bitc <= '0; tx <= next_rd; sda_oe_o <= ~next_rd[BYTE_W-1];
              bidx <= ~bidx; state <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0; state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the address acknowledge phase is only ever reached with a matching address
  assert_addr_match_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK) |-> (shreg[7:1] == {ADDR_FIXED, strap_i}));
  // R3: the pointer acknowledge phase only follows a byte with clear reserved bits
  assert_ptr_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PACK) |-> (shreg[7:2] == '0));
  // R4: a refused pointer byte leaves the stored pointer untouched
  assert_ptr_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PTR && byte_done && !ptr_ok) |=> $stable(ptr));
  // R9: any start puts the receiver back at the first address bit
  assert_restart_addr_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (state == ST_ADDR && bitc == '0));
  // R10: the SDA driver moves only after an SCL fall, a start or a stop
  assert_oe_timing_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall | start | stop));
  // R10: a stop always leaves SDA released
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sda_oe_o);
endmodule

// File: tb/sim_tw_ptr_slave.sv
module sim_tw_ptr_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [15:0] temp = 16'h1970;
  logic oe;
  logic [7:0] cfg;
  logic [15:0] hyst, olim;
  wire line = sda_m & ~oe;

  always #10 clk = ~clk;

  tw_ptr_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .strap_i(strap),
    .temp_i(temp), .sda_oe_o(oe), .cfg_o(cfg), .hyst_o(hyst), .olim_o(olim));

  localparam logic [7:0] AW = 8'h9A;   // 7'h4D, write
  localparam logic [7:0] AR = 8'h9B;   // 7'h4D, read
  localparam logic [7:0] AX = 8'h96;   // 7'h4B, write (not ours)

  // {pointer, write hi, write lo, expected read hi, expected read lo}
  localparam logic [39:0] VEC [0:5] = '{
    40'h01_A5_00_A5_00,
    40'h02_12_34_12_34,
    40'h03_FE_DC_FE_DC,
    40'h00_55_AA_19_70,
    40'h02_00_FF_00_FF,
    40'h01_3C_00_3C_00
  };

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ph;
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; ph; scl_m = 1'b1; ph; sda_m = 1'b0; ph; scl_m = 1'b0; ph;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; ph; scl_m = 1'b1; ph; sda_m = 1'b1; ph;
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; ph; scl_m = 1'b1; ph; r = line; ph; scl_m = 1'b0; ph;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~mack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3, a4;
    logic [7:0] h, l, x;
    logic r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1: reset state at the ports
    chk(oe == 1'b0, "R1 oe", 32'(oe), 0);
    chk(cfg == 8'h00, "R1 cfg", 32'(cfg), 32'h00);
    chk(hyst == 16'h4B00, "R1 hyst", 32'(hyst), 32'h4B00);
    chk(olim == 16'h5000, "R1 olim", 32'(olim), 32'h5000);
    // R1 R5: pointer starts at temperature; read with no pointer write
    bus_start; wr_byte(AR, a0); rd_byte(1'b1, h); rd_byte(1'b0, l); bus_stop;
    chk(a0 && {h, l} == temp, "R1 R5 reset pointer read", {15'd0, a0, h, l}, {16'd1, temp});

    // table walk: write via pointer, read back through pointer + repeated start
    for (int v = 0; v < 6; v++) begin
      logic [7:0] p, wh, wl, eh, el;
      {p, wh, wl, eh, el} = VEC[v];
      bus_start; wr_byte(AW, a0); wr_byte(p, a1); wr_byte(wh, a2);
      if (p != 8'h01) wr_byte(wl, a3); else a3 = 1'b1;
      bus_stop;
      chk(a0 && a1 && a2 && a3, "R2 R3 R6 R7 write acks", {28'd0, a0, a1, a2, a3}, 32'hF);
      bus_start; wr_byte(AW, a0); wr_byte(p, a1); bus_start; wr_byte(AR, a4);
      if (p == 8'h01) begin
        rd_byte(1'b0, h); l = 8'h00;
      end else begin
        rd_byte(1'b1, h); rd_byte(1'b0, l);
      end
      bus_stop;
      chk(a0 && a1 && a4 && {h, l} == {eh, el}, "R6 R7 R8 readback",
          {13'd0, a0, a1, a4, h, l}, {16'h0007, eh, el});
      if (p == 8'h01) chk(cfg == wh, "R6 cfg port", 32'(cfg), 32'(wh));
      if (p == 8'h02) chk(hyst == {wh, wl}, "R6 hyst port", 32'(hyst), {16'd0, wh, wl});
      if (p == 8'h03) chk(olim == {wh, wl}, "R6 olim port", 32'(olim), {16'd0, wh, wl});
      if (p == 8'h00) chk(cfg == 8'hA5 && hyst == 16'h1234 && olim == 16'hFEDC,
                          "R7 temp write discarded", {cfg, hyst}, {8'hA5, 16'h1234});
    end

    // R2: foreign address gets no ACK and later bytes are ignored
    bus_start; wr_byte(AX, a0); wr_byte(8'h01, a1); wr_byte(8'h77, a2); bus_stop;
    chk(!a0 && !a1 && !a2, "R2 mismatch no ack", {29'd0, a0, a1, a2}, 0);
    chk(cfg == 8'h3C, "R2 mismatch no write", 32'(cfg), 32'h3C);

    // R4: bad pointer refused, following byte ignored, pointer kept (01)
    bus_start; wr_byte(AW, a0); wr_byte(8'h05, a1); wr_byte(8'h11, a2); bus_stop;
    chk(a0 && !a1 && !a2, "R4 bad pointer nack", {29'd0, a0, a1, a2}, 32'h4);
    chk(cfg == 8'h3C, "R4 no write after refusal", 32'(cfg), 32'h3C);
    bus_start; wr_byte(AR, a0); rd_byte(1'b0, h); bus_stop;
    chk(a0 && h == 8'h3C, "R4 R5 pointer unchanged", {23'd0, a0, h}, 32'h13C);

    // R6: one byte to a 16-bit register does not update it
    bus_start; wr_byte(AW, a0); wr_byte(8'h02, a1); wr_byte(8'hAB, a2); bus_stop;
    chk(a2 && hyst == 16'h00FF, "R6 half write held", {15'd0, a2, hyst}, 32'h100FF);

    // R5: pointer set in one transaction, read in a later one
    bus_start; wr_byte(AW, a0); wr_byte(8'h03, a1); bus_stop;
    bus_start; wr_byte(AR, a0); rd_byte(1'b1, h); rd_byte(1'b0, l);
    chk(oe == 1'b0, "R8 release after nack", 32'(oe), 0);
    bus_stop;
    chk({h, l} == 16'hFEDC, "R5 retained pointer", {16'd0, h, l}, 32'hFEDC);
    chk(oe == 1'b0, "R10 released after stop", 32'(oe), 0);

    // R8: master keeps ACKing: high, low, high again
    bus_start; wr_byte(AW, a0); wr_byte(8'h02, a1); bus_start; wr_byte(AR, a0);
    rd_byte(1'b1, h); rd_byte(1'b1, l); rd_byte(1'b0, x); bus_stop;
    chk({h, l, x} == 24'h00FF00, "R8 alternating bytes", {8'd0, h, l, x}, 32'h00FF00);

    // R9: repeated start in the middle of a data byte
    bus_start; wr_byte(AW, a0); wr_byte(8'h01, a1);
    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r); bus_bit(1'b0, r);
    bus_start; wr_byte(AR, a4); rd_byte(1'b0, h); bus_stop;
    chk(a4 && h == 8'h3C && cfg == 8'h3C, "R9 restart mid byte", {15'd0, a4, h, cfg}, 32'h13C3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule